// File: doc/BRIEF.md
# Planar Pixel Decoder and Serializer

This block turns one fetched display byte into a run of coloured pixels. The byte arrives with its colour planes bit-interleaved. At load time the block regroups the bits into packed pixels of 1, 2 or 4 bits, according to the selected colour depth. The pixels are then shifted out one at a time, most significant first. Each pixel value goes through a 16-entry palette to a 1-bit-per-channel RGB output.

A one-hot phase input, one bit per slot of the pixel period, sets when the shift register advances. Together with the scale selection this stretches each pixel over one, two or four output slots. A companion tag register is loaded with a single one and shifts left with zero fill. It counts down the pixels a byte still holds. The output is black once the tag empties and stays black until the next load. Memory fetch and timing generation are outside the block.

Top module: `ppd_serializer`

## Requirements
- R1: After reset, and until the first load, `rgb_o` is 3'b000.
- R2: With depth code 1 the loaded byte is used as is. It yields 8 one-bit pixels, bit 7 first and bit 0 last.
- R3: With depth code 2 the byte yields 4 two-bit pixels. Pixel k (k = 0..3) is {b[7-k], b[3-k]}.
- R4: With depth code 4 the byte yields 2 four-bit pixels. Pixel k (k = 0..1) is {b[7-k], b[5-k], b[3-k], b[1-k]}.
- R5: A depth code other than 1, 2 or 4 behaves exactly like depth code 1.
- R6: Pixel value v is shown as rgb_o[2] = v[0] (red), rgb_o[1] = v[1] (green) and rgb_o[0] = v[2] (blue). Values 8..15 show the same colour as v-8.
- R7: With scale code 1 (or any code other than 2 or 4) the pixel advances at every clock edge without a load.
- R8: With scale code 2 the pixel advances only at edges where phase_i & 8'h55 is nonzero. At other edges `rgb_o` holds.
- R9: With scale code 4 the pixel advances only at edges where phase_i & 8'h11 is nonzero.
- R10: Once the last pixel of a byte has been advanced past, `rgb_o` is black until the next load.
- R11: A load takes priority over advancing. It discards the remaining pixels and shows pixel 0 of the new byte after that same edge.
- R12: The depth is captured at load. Changing depth_i while a byte is being shifted changes neither its pixel values nor its pixel count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture byte_i and depth_i at this edge |
| byte_i | input | 8 | Fetched byte in planar interleaved layout |
| depth_i | input | 3 | Bits per pixel: 1, 2 or 4 |
| scale_i | input | 3 | Horizontal stretch: 1, 2 or 4 |
| phase_i | input | 8 | One-hot slot within the pixel period |
| rgb_o | output | 3 | {red, green, blue} of the current pixel |

## Verification
A wrong regrouping or palette entry shows up on `rgb_o` in the first cycle after the load. A stuck or mis-shifted tag shows up as a byte that ends a pixel early or late, or that never goes black. A phase mask with a bit in the wrong position only shows at slots of that phase. For that reason every scale is run across a full rotation of the one-hot phase, and each pixel's duration is compared slot by slot.

// File: rtl/ppd_pkg.sv
package ppd_pkg;
  localparam int unsigned PIX_W = 4;   // widest pixel
  localparam int unsigned RGB_W = 3;

  typedef enum logic [1:0] {DEPTH_1, DEPTH_2, DEPTH_4} depth_e;
  typedef enum logic [1:0] {SCALE_1, SCALE_2, SCALE_4} scale_e;

  function automatic depth_e decode_depth(input logic [2:0] code);
    case (code)
      3'd2:    return DEPTH_2;
      3'd4:    return DEPTH_4;
      default: return DEPTH_1;
    endcase
  endfunction

  function automatic scale_e decode_scale(input logic [2:0] code);
    case (code)
      3'd2:    return SCALE_2;
      3'd4:    return SCALE_4;
      default: return SCALE_1;
    endcase
  endfunction
endpackage

// File: rtl/ppd_unpack.sv
module ppd_unpack
  import ppd_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] planar_i,
  input  depth_e            depth_i,
  output logic [DATA_W-1:0] packed_o
);
  localparam int unsigned N2 = DATA_W / 2;
  localparam int unsigned N4 = DATA_W / 4;

  logic [DATA_W-1:0] pk2, pk4;

  // pixel k, bit j: plane (d-1-j) sits n bits below its neighbour
  for (genvar k = 0; k < N2; k++) begin : g_d2
    for (genvar j = 0; j < 2; j++) begin : g_bit
      assign pk2[DATA_W-1-(k*2+(1-j))] = planar_i[DATA_W-1-k-(1-j)*N2];
    end
  end

  for (genvar k = 0; k < N4; k++) begin : g_d4
    for (genvar j = 0; j < 4; j++) begin : g_bit
      assign pk4[DATA_W-1-(k*4+(3-j))] = planar_i[DATA_W-1-k-(3-j)*N4];
    end
  end

  always_comb begin
    case (depth_i)
      DEPTH_2: packed_o = pk2;
      DEPTH_4: packed_o = pk4;
      default: packed_o = planar_i;
    endcase
  end
endmodule

// File: rtl/ppd_pace.sv
module ppd_pace
  import ppd_pkg::*;
#(
  parameter int unsigned PHASE_W = 8
) (
  input  logic [PHASE_W-1:0] phase_i,
  input  scale_e             scale_i,
  output logic               adv_o
);
  logic [PHASE_W-1:0] mask2, mask4;

  for (genvar i = 0; i < PHASE_W; i++) begin : g_mask
    assign mask2[i] = ((i % 2) == 0);
    assign mask4[i] = ((i % 4) == 0);
  end

  always_comb begin
    case (scale_i)
      SCALE_2: adv_o = |(phase_i & mask2);
      SCALE_4: adv_o = |(phase_i & mask4);
      default: adv_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/ppd_shift.sv
module ppd_shift
  import ppd_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] packed_i,
  input  depth_e            depth_i,
  input  logic              adv_i,
  output logic [PIX_W-1:0]  pix_o,
  output logic [DATA_W-1:0] tag_o
);
  localparam logic [DATA_W-1:0] TAG_INIT = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] data_q, data_nx, tag_q, tag_nx;
  depth_e            depth_q;

  always_comb begin
    case (depth_q)
      DEPTH_2: begin
        data_nx = {data_q[DATA_W-3:0], data_q[DATA_W-1 -: 2]};
        tag_nx  = {tag_q[DATA_W-3:0], 2'b00};
      end
      DEPTH_4: begin
        data_nx = {data_q[DATA_W-5:0], data_q[DATA_W-1 -: 4]};
        tag_nx  = {tag_q[DATA_W-5:0], 4'b0000};
      end
      default: begin
        data_nx = {data_q[DATA_W-2:0], data_q[DATA_W-1]};
        tag_nx  = {tag_q[DATA_W-2:0], 1'b0};
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      tag_q   <= '0;
      depth_q <= DEPTH_1;
    end else if (load_i) begin
      data_q  <= packed_i;
      tag_q   <= TAG_INIT;
      depth_q <= depth_i;
    end else if (adv_i && (|tag_q)) begin
      data_q  <= data_nx;
      tag_q   <= tag_nx;
    end
  end

  always_comb begin
    case (depth_q)
      DEPTH_2: pix_o = {2'b00, data_q[DATA_W-1 -: 2]};
      DEPTH_4: pix_o = data_q[DATA_W-1 -: 4];
      default: pix_o = {3'b000, data_q[DATA_W-1]};
    endcase
  end

  assign tag_o = tag_q;
endmodule

// File: rtl/ppd_palette.sv
module ppd_palette
  import ppd_pkg::*;
#(
  parameter int unsigned PAL_N = 16
) (
  input  logic [PIX_W-1:0] pix_i,
  input  logic             active_i,
  output logic [RGB_W-1:0] rgb_o
);
  logic [RGB_W-1:0] tbl [PAL_N];

  for (genvar i = 0; i < PAL_N; i++) begin : g_ent
    localparam logic [2:0] C = 3'(i % 8);
    assign tbl[i] = {C[0], C[1], C[2]};
  end

  assign rgb_o = active_i ? tbl[pix_i] : '0;
endmodule

// File: rtl/ppd_serializer.sv
module ppd_serializer
  import ppd_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PHASE_W = 8,
  parameter int unsigned PAL_N   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [DATA_W-1:0]  byte_i,
  input  logic [2:0]         depth_i,
  input  logic [2:0]         scale_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic [RGB_W-1:0]   rgb_o
);
  depth_e            depth_sel;
  scale_e            scale_sel;
  logic [DATA_W-1:0] packed_w, tag_w;
  logic [PIX_W-1:0]  pix_w;
  logic              adv_w;

  assign depth_sel = decode_depth(depth_i);
  assign scale_sel = decode_scale(scale_i);

  ppd_unpack #(.DATA_W(DATA_W)) i_unpack (
    .planar_i (byte_i),
    .depth_i  (depth_sel),
    .packed_o (packed_w)
  );

  ppd_pace #(.PHASE_W(PHASE_W)) i_pace (
    .phase_i (phase_i),
    .scale_i (scale_sel),
    .adv_o   (adv_w)
  );

  ppd_shift #(.DATA_W(DATA_W)) i_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .packed_i (packed_w),
    .depth_i  (depth_sel),
    .adv_i    (adv_w),
    .pix_o    (pix_w),
    .tag_o    (tag_w)
  );

  ppd_palette #(.PAL_N(PAL_N)) i_palette (
    .pix_i    (pix_w),
    .active_i (|tag_w),
    .rgb_o    (rgb_o)
  );
endmodule

// File: rtl/ppd_serializer_chk.sv
module ppd_serializer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       load_i,
  input logic [7:0] byte_i,
  input logic [2:0] depth_i,
  input logic [2:0] scale_i,
  input logic [7:0] phase_i,
  input logic [2:0] rgb_o,
  input logic [7:0] tag_w
);
  AST_D1_FIRST_PIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && depth_i == 3'd1 |=> rgb_o == {$past(byte_i[7]), 2'b00}); // R2

  AST_D4_FIRST_PIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && depth_i == 3'd4 |=> rgb_o == {$past(byte_i[1]), $past(byte_i[3]), $past(byte_i[5])}); // R4

  AST_SCALE2_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && scale_i == 3'd2 && (phase_i & 8'h55) == 8'h00 |=> $stable(rgb_o)); // R8

  AST_SCALE4_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && scale_i == 3'd4 && (phase_i & 8'h11) == 8'h00 |=> $stable(rgb_o)); // R9

  AST_DRAINED_BLACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && tag_w == 8'h00 |=> rgb_o == 3'b000); // R10

  AST_TAG_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tag_w)); // R10
endmodule

bind ppd_serializer ppd_serializer_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .load_i  (load_i),
  .byte_i  (byte_i),
  .depth_i (depth_i),
  .scale_i (scale_i),
  .phase_i (phase_i),
  .rgb_o   (rgb_o),
  .tag_w   (tag_w)
);

// File: tb/test_ppd_serializer.sv
`timescale 1ns/1ps
module test_ppd_serializer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic [2:0] depth_i = 3'd1;
  logic [2:0] scale_i = 3'd1;
  logic [7:0] phase_i = 8'h01;
  logic [2:0] rgb_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ppd_serializer i_ppd_serializer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .byte_i(byte_i),
    .depth_i(depth_i), .scale_i(scale_i), .phase_i(phase_i), .rgb_o(rgb_o)
  );

  function automatic logic [2:0] colour(input logic [3:0] v);
    return {v[0], v[1], v[2]};
  endfunction

  function automatic logic [2:0] exp_pix(input logic [7:0] b, input int d, input int k);
    logic [3:0] v;
    case (d)
      2:       v = {2'b00, b[7-k], b[3-k]};
      4:       v = {b[7-k], b[5-k], b[3-k], b[1-k]};
      default: v = {3'b000, b[7-k]};
    endcase
    return colour(v);
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s rgb actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_load(input logic [7:0] b, input logic [2:0] d);
    byte_i  = b;
    depth_i = d;
    load_i  = 1'b1;
    @(negedge clk_i);
    load_i  = 1'b0;
  endtask

  // byte already loaded and pixel 0 on the output; ticks through phases
  task automatic run_ticks(input logic [7:0] b, input int d, input int s, input string req);
    int ptr = 0;
    int n = 8 / d;
    check(req, rgb_o, exp_pix(b, d, 0));
    for (int j = 0; j < 8 * s + 4; j++) begin
      phase_i = 8'h01 << (j % 8);
      @(negedge clk_i);
      if (j % s == 0) ptr++;
      check(req, rgb_o, (ptr < n) ? exp_pix(b, d, ptr) : 3'b000);
    end
  endtask

  task automatic run_stream(input logic [7:0] b, input logic [2:0] dcode, input int d,
                            input logic [2:0] scode, input int s, input string req);
    scale_i = scode;
    do_load(b, dcode);
    run_ticks(b, d, s, req);
  endtask

  task automatic t_reset;
    check("R1", rgb_o, 3'b000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) begin
      phase_i = 8'h01 << i;
      @(negedge clk_i);
      check("R1", rgb_o, 3'b000);
    end
  endtask

  task automatic t_depth1;
    run_stream(8'hA5, 3'd1, 1, 3'd1, 1, "R2 R7");
    run_stream(8'h3C, 3'd1, 1, 3'd1, 1, "R2 R10");
  endtask

  task automatic t_depth2;
    run_stream(8'hB4, 3'd2, 2, 3'd1, 1, "R3");
    run_stream(8'h1E, 3'd2, 2, 3'd1, 1, "R3 R10");
  endtask

  task automatic t_depth4;
    run_stream(8'hC9, 3'd4, 4, 3'd1, 1, "R4");
    run_stream(8'h72, 3'd4, 4, 3'd7, 1, "R4 R7");
  endtask

  task automatic t_bad_depth;
    run_stream(8'h6B, 3'd3, 1, 3'd1, 1, "R5");
    run_stream(8'h94, 3'd0, 1, 3'd1, 1, "R5");
  endtask

  task automatic t_palette;
    for (int v = 0; v < 16; v++) begin
      logic [3:0] p = 4'(v);
      logic [3:0] w = 4'(15 - v);
      run_stream({p[3], w[3], p[2], w[2], p[1], w[1], p[0], w[0]}, 3'd4, 4, 3'd1, 1, "R6");
    end
  endtask

  task automatic t_scale2;
    run_stream(8'hD2, 3'd1, 1, 3'd2, 2, "R8");
    run_stream(8'h87, 3'd4, 4, 3'd2, 2, "R8");
  endtask

  task automatic t_scale4;
    run_stream(8'hE1, 3'd2, 2, 3'd4, 4, "R9");
    run_stream(8'h59, 3'd1, 1, 3'd4, 4, "R9");
  endtask

  task automatic t_reload;
    scale_i = 3'd1;
    do_load(8'hF0, 3'd1);
    check("R11", rgb_o, exp_pix(8'hF0, 1, 0));
    for (int j = 0; j < 2; j++) begin
      phase_i = 8'h01 << j;
      @(negedge clk_i);
    end
    do_load(8'h55, 3'd1);
    run_ticks(8'h55, 1, 1, "R11");
  endtask

  task automatic t_depth_latch;
    scale_i = 3'd1;
    do_load(8'hC9, 3'd4);
    depth_i = 3'd1;
    run_ticks(8'hC9, 4, 1, "R12");
    do_load(8'h2D, 3'd2);
    depth_i = 3'd4;
    run_ticks(8'h2D, 2, 1, "R12");
  endtask

  initial begin
    t_reset();
    t_depth1();
    t_depth2();
    t_depth4();
    t_bad_depth();
    t_palette();
    t_scale2();
    t_scale4();
    t_reload();
    t_depth_latch();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule